// File: doc/BRIEF.md
# Zero-Flag Arithmetic-Logic Unit

This block is a purely combinational arithmetic-logic unit for a simple processor datapath. It takes two operand words and a 4-bit operation code. It returns a result word and a single-bit flag that marks an all-zero result. The surrounding pipeline uses it for three jobs: register arithmetic, memory address generation, and branch resolution. For an equality branch, the pipeline requests a subtract and reads the flag.

A small decoder turns the operation code into a bundle of strobes. A datapath then forms the bitwise, arithmetic and comparison results and merges the one that is selected. There is no clock, reset or internal state. Every output settles from the current inputs alone.

Top module: `alu_unit`

## Requirements
- R1: Operation code 4'b0000 gives the bitwise AND of the two operands.
- R2: Operation code 4'b0001 gives the bitwise OR of the two operands.
- R3: Operation code 4'b0010 gives the sum of the operands modulo 2^32, with no overflow indication.
- R4: Operation code 4'b0110 gives operand A minus operand B modulo 2^32. Subtracting equal operands yields zero.
- R5: Operation code 4'b0111 compares the operands as signed two's-complement numbers. It returns 1 in bit 0 when A is less than B and 0 otherwise, with bits 31..1 always zero.
- R6: Operation code 4'b1100 gives the bitwise NOR of the two operands.
- R7: For every operation code, the zero flag is 1 exactly when all 32 result bits are 0.
- R8: Any operation code other than the six listed yields a result of zero, and therefore a zero flag of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opCode | input | 4 | Operation select |
| aluResult | output | 32 | Result of the selected operation |
| isZero | output | 1 | High when aluResult is all zeros |

## Verification
All sixteen operation codes are swept against every pair drawn from a set of boundary operands:
- zero and one;
- all ones;
- the most positive and most negative values;
- alternating bit patterns.

The extreme pairs separate a signed comparison from an unsigned one, and they separate a wrapped sum from a saturated one. Equal pairs under subtract exercise the branch-equality use of the flag. The alternating patterns separate AND, OR and NOR bit for bit. A further run of pseudo-random operand pairs, drawn from a shift-register sequence across the six listed codes, catches carry-chain errors that the boundary set might miss. The unlisted codes confirm that only the six listed operations ever produce a nonzero result.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0110,
    OP_SLT = 4'b0111,
    OP_NOR = 4'b1100
  } alu_op_e;

  // strobes from decoder to datapath
  typedef struct packed {
    logic pickAnd;   // route bitwise AND
    logic pickOr;    // route bitwise OR (optionally inverted)
    logic pickSum;   // route adder output
    logic pickLess;  // route signed comparison bit
    logic negB;      // adder computes A + ~B + 1
    logic invOr;     // invert OR result (NOR)
  } alu_ctrl_t;

endpackage

// File: rtl/alu_control.sv
module alu_control
  import alu_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output alu_ctrl_t       ctrl
);

  always_comb begin
    ctrl = '0;
    case (opCode)
      OP_AND: ctrl.pickAnd = 1'b1;                                   // R1
      OP_OR:  ctrl.pickOr  = 1'b1;                                   // R2
      OP_ADD: ctrl.pickSum = 1'b1;                                   // R3
      OP_SUB: begin ctrl.pickSum  = 1'b1; ctrl.negB = 1'b1; end      // R4
      OP_SLT: begin ctrl.pickLess = 1'b1; ctrl.negB = 1'b1; end      // R5
      OP_NOR: begin ctrl.pickOr   = 1'b1; ctrl.invOr = 1'b1; end     // R6
      default: ctrl = '0;                                            // R8
    endcase
  end

  always_comb begin
    AST_ONE_SOURCE: assert ($onehot0({ctrl.pickAnd, ctrl.pickOr, ctrl.pickSum, ctrl.pickLess})); // R8
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  alu_ctrl_t        ctrl,
  output logic [WIDTH-1:0] result,
  output logic             zeroOut
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] andVal, orVal, bAdj, sumVal, lessVal;
  logic             lessBit;

  assign andVal = opA & opB;
  assign orVal  = ctrl.invOr ? ~(opA | opB) : (opA | opB);
  assign bAdj   = ctrl.negB ? ~opB : opB;
  assign sumVal = opA + bAdj + {{(WIDTH-1){1'b0}}, ctrl.negB};

  // signs differ: A is less iff A negative; else the difference sign decides
  assign lessBit = (opA[MSB] ^ opB[MSB]) ? opA[MSB] : sumVal[MSB];
  assign lessVal = {{(WIDTH-1){1'b0}}, lessBit};

  always_comb begin
    result = '0;
    if (ctrl.pickAnd)  result = result | andVal;
    if (ctrl.pickOr)   result = result | orVal;
    if (ctrl.pickSum)  result = result | sumVal;
    if (ctrl.pickLess) result = result | lessVal;
  end

  assign zeroOut = ~|result;

  always_comb begin
    if (ctrl.pickLess)
      AST_LESS_UPPER_CLEAR: assert (result[MSB:1] == '0); // R5
  end

endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [OP_W-1:0]  opCode,
  output logic [WIDTH-1:0] aluResult,
  output logic             isZero
);

  alu_ctrl_t ctrlBus;

  alu_control u_ctrl (
    .opCode (opCode),
    .ctrl   (ctrlBus)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .ctrl    (ctrlBus),
    .result  (aluResult),
    .zeroOut (isZero)
  );

  logic listedOp;
  assign listedOp = (opCode == OP_AND) || (opCode == OP_OR) || (opCode == OP_ADD) ||
                    (opCode == OP_SUB) || (opCode == OP_SLT) || (opCode == OP_NOR);

  always_comb begin
    if (!listedOp)
      AST_UNLISTED_ZERO: assert (aluResult == '0 && isZero); // R8
    if (opCode == OP_SUB && opA == opB)
      AST_SUB_EQUAL_FLAG: assert (isZero); // R4
    if (isZero)
      AST_FLAG_MEANS_ZERO: assert (aluResult == '0); // R7
    if (opCode == OP_AND)
      AST_AND_SUBSET: assert ((aluResult & ~opA) == '0); // R1
  end

endmodule

// File: tb/sim_alu_unit.sv
module sim_alu_unit;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] opA, opB;
  logic [3:0]  opCode;
  logic [31:0] aluResult;
  logic        isZero;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  alu_unit u0 (
    .opA       (opA),
    .opB       (opB),
    .opCode    (opCode),
    .aluResult (aluResult),
    .isZero    (isZero)
  );

  function automatic logic [31:0] model(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
    case (c)
      4'b0000: return a & b;                                      // R1
      4'b0001: return a | b;                                      // R2
      4'b0010: return a + b;                                      // R3
      4'b0110: return a - b;                                      // R4
      4'b0111: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;  // R5
      4'b1100: return ~(a | b);                                   // R6
      default: return 32'd0;                                      // R8
    endcase
  endfunction

  function automatic string reqTag(input logic [3:0] c);
    case (c)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      4'b1100: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic applyCheck(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] expR;
    logic        expZ;
    @(negedge clk);
    opCode = c; opA = a; opB = b;
    #1;
    expR = model(c, a, b);
    expZ = (expR == 32'd0);
    checks++;
    if (aluResult !== expR) begin
      errors++;
      $display("FAIL %s op=%b a=%h b=%h result actual=%h expected=%h", reqTag(c), c, a, b, aluResult, expR);
    end
    checks++;
    if (isZero !== expZ) begin
      errors++;
      $display("FAIL R7 op=%b a=%h b=%h zero actual=%b expected=%b", c, a, b, isZero, expZ);
    end
  endtask

  logic [31:0] corner [8];

  initial begin
    logic [31:0] lfsr;
    logic [3:0]  listed [6];
    corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
    corner[2] = 32'hFFFF_FFFF; corner[3] = 32'h7FFF_FFFF;
    corner[4] = 32'h8000_0000; corner[5] = 32'h5555_5555;
    corner[6] = 32'hAAAA_AAAA; corner[7] = 32'h0000_0002;
    listed[0] = 4'b0000; listed[1] = 4'b0001; listed[2] = 4'b0010;
    listed[3] = 4'b0110; listed[4] = 4'b0111; listed[5] = 4'b1100;
    opA = '0; opB = '0; opCode = '0;

    // R5: extreme signed comparisons
    applyCheck(4'b0111, 32'h8000_0000, 32'h7FFF_FFFF); // expect 1
    applyCheck(4'b0111, 32'h7FFF_FFFF, 32'h8000_0000); // expect 0
    applyCheck(4'b0111, 32'hFFFF_FFFF, 32'h0000_0000); // expect 1
    // R4: equal operands give zero flag
    applyCheck(4'b0110, 32'h1234_5678, 32'h1234_5678);
    // R3: wrap
    applyCheck(4'b0010, 32'hFFFF_FFFF, 32'h0000_0001);

    // every code against every corner pair (R1..R8)
    for (int c = 0; c < 16; c++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          applyCheck(4'(c), corner[i], corner[j]);

    // pseudo-random operands on listed codes
    lfsr = 32'hACE1_2468;
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] ra, rb;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ra = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      rb = lfsr;
      applyCheck(listed[n % 6], ra, rb);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 100000; k++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule